// File: doc/BRIEF.md
# Software-Generated Interrupt Security Filter

This block sits between the source of software-generated interrupt requests and the per-processor pending state. A request names one of sixteen interrupts, the group it asks for (group 0, secure group 1 or non-secure group 1), and whether it comes from a non-secure originator. The filter works out the group the target interrupt is actually configured into, from its group bit, its modifier bit and the global security-disable flag. It then decides whether the request may set that interrupt's pending bit.

A request for secure group 1 that targets a group 0 interrupt falls back to a group 0 request. A group 0 request that targets an interrupt in any other group is refused. When security is enabled, a non-secure originator must also pass a graded 2-bit permission field kept for each interrupt. Requests with an out-of-range ID are refused and flagged.

The verdict is registered. One clock after the request, the block emits either a set-pending strobe carrying the ID, which the pending logic also uses to start a new priority evaluation, or a drop strobe with a reason code.

Top module: `sgi_gate`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pend_set` and `drop` are both 0, whatever the request inputs are.
- R2: A request sampled with `req_valid`=1 produces, in the next cycle, exactly one of `pend_set` or `drop` for one cycle. A cycle without a request produces neither.
- R3: A request with `req_id` of 16 or more is dropped with `drop_why`=3 (invalid ID).
- R4: With `sec_off`=0, the configured group of interrupt n comes from {modifier bit n, group bit n}. 00 gives group 0, 10 gives secure group 1, and 01 or 11 give non-secure group 1.
- R5: With `sec_off`=1, group bit n = 0 gives group 0 and group bit n = 1 gives non-secure group 1. The modifier bit has no effect.
- R6: A request coded secure group 1 (`req_grp`=1) that targets a group 0 interrupt is treated as a group 0 request.
- R7: A group 0 request (`req_grp`=0, or after the fallback of R6) that targets an interrupt not configured as group 0 is dropped with `drop_why`=1.
- R8: The permission field is consulted only when `req_ns`=1 and `sec_off`=0. A permission drop reports `drop_why`=2.
- R9: A non-secure request is dropped if the target is group 0 and its field is below 1, or if the target is secure group 1 and its field is below 2. A target in non-secure group 1 is never dropped on permission grounds.
- R10: The permission field of interrupt n is `nsac_word[2n+1:2n]`.
- R11: On acceptance, `pend_id` equals the low four bits of the request ID and `drop_why` is 0.
- R12: The unused group code `req_grp`=3 is dropped with `drop_why`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_id | input | 5 | Requested interrupt ID |
| req_grp | input | 2 | Requested group: 0 group 0, 1 secure group 1, 2 non-secure group 1, 3 unused |
| req_ns | input | 1 | Request comes from a non-secure originator |
| sec_off | input | 1 | Global security-disable flag |
| grp_bits | input | 16 | Group bit per interrupt |
| mod_bits | input | 16 | Group modifier bit per interrupt |
| nsac_word | input | 32 | Packed 2-bit non-secure permission fields |
| pend_set | output | 1 | Set-pending strobe, which also requests a priority re-evaluation |
| pend_id | output | 4 | Interrupt whose pending bit is set |
| drop | output | 1 | Request refused |
| drop_why | output | 2 | 0 none, 1 group mismatch, 2 permission, 3 invalid ID |

## Verification
The embedded properties check the following on every cycle:
- the one-cycle response and the mutual exclusion of the two strobes;
- that the set-pending ID matches the request;
- that invalid IDs and the unused group code always produce the right drop reason;
- that a permission drop never occurs unless the originator is non-secure with security enabled.

The group resolution table, the fallback rule, the permission thresholds and the placement of each field in the packed word depend on the configuration values. Only the bench's vectors can show them. The bench inverts the configuration of every interrupt other than the target, so that a mis-indexed lookup shows up as a wrong verdict.

// File: rtl/sgi_gate_pkg.sv
// Package: shared encodings for the software-generated interrupt filter.
// Assumes: two-bit group and reason codes, used on the ports unchanged.
package sgi_gate_pkg;

    typedef enum logic [1:0] {
        GRP_G0   = 2'd0,
        GRP_G1S  = 2'd1,
        GRP_G1NS = 2'd2,
        GRP_RSV  = 2'd3
    } sgi_grp_e;

    typedef enum logic [1:0] {
        WHY_NONE  = 2'd0,
        WHY_GROUP = 2'd1,
        WHY_PERM  = 2'd2,
        WHY_BADID = 2'd3
    } sgi_why_e;

    // Resolve the configured group from the modifier bit, group bit and security mode.
    function automatic sgi_grp_e resolve_grp(input logic modb, input logic grpb, input logic secoff);
        if (grpb)
            return GRP_G1NS;
        else if (modb && !secoff)
            return GRP_G1S;
        else
            return GRP_G0;
    endfunction

endpackage

// File: rtl/sgi_grp_map.sv
// Module: sgi_grp_map
// Computes the configured group of every interrupt in parallel.
// Assumes: one group bit and one modifier bit per interrupt. With security
// disabled the modifier bit is ignored.
module sgi_grp_map
    import sgi_gate_pkg::*;
#(
    parameter int N_INT = 16
) (
    input  logic [N_INT-1:0]      grp_bits,
    input  logic [N_INT-1:0]      mod_bits,
    input  logic                  sec_off,
    output logic [N_INT-1:0][1:0] cfg_grp
);
    for (genvar n = 0; n < N_INT; n++) begin : g_int
        // Per-interrupt group resolution.
        always_comb cfg_grp[n] = resolve_grp(mod_bits[n], grp_bits[n], sec_off);
    end
endmodule

// File: rtl/sgi_acl_unpack.sv
// Module: sgi_acl_unpack
// Splits the packed permission word into one field per interrupt.
// Assumes: interrupt n occupies bits [AC_W*n+AC_W-1 : AC_W*n].
module sgi_acl_unpack #(
    parameter int N_INT = 16,
    parameter int AC_W  = 2
) (
    input  logic [N_INT*AC_W-1:0]      nsac_word,
    output logic [N_INT-1:0][AC_W-1:0] acl
);
    for (genvar n = 0; n < N_INT; n++) begin : g_fld
        // Slice the field that belongs to interrupt n.
        always_comb acl[n] = nsac_word[AC_W*n +: AC_W];
    end
endmodule

// File: rtl/sgi_verdict.sv
// Module: sgi_verdict
// Combinational accept/drop decision for a single request.
// Assumes: the configured groups and permission fields are already
// unpacked per interrupt. The caller registers the result.
module sgi_verdict
    import sgi_gate_pkg::*;
#(
    parameter int N_INT      = 16,
    parameter int ID_W       = 5,
    parameter int AC_W       = 2,
    parameter int MIN_AC_G0  = 1,
    parameter int MIN_AC_G1S = 2
) (
    input  logic [ID_W-1:0]            req_id,
    input  logic [1:0]                 req_grp,
    input  logic                       req_ns,
    input  logic                       sec_off,
    input  logic [N_INT-1:0][1:0]      cfg_grp,
    input  logic [N_INT-1:0][AC_W-1:0] acl,
    output logic                       accept,
    output logic [1:0]                 why
);
    localparam int IDX_W = (N_INT > 1) ? $clog2(N_INT) : 1;

    logic              id_ok;
    logic [IDX_W-1:0]  idx;
    sgi_grp_e          tgt_grp;
    sgi_grp_e          eff_req;
    logic [AC_W-1:0]   tgt_acl;
    logic              perm_ok;

    // Range check and index of the target interrupt.
    always_comb begin
        id_ok = (int'(req_id) < N_INT);
        idx   = id_ok ? req_id[IDX_W-1:0] : '0;
    end

    // Fetch the target's configuration.
    always_comb begin
        tgt_grp = sgi_grp_e'(cfg_grp[idx]);
        tgt_acl = acl[idx];
    end

    // Secure group 1 requests on a group 0 target fall back to group 0.
    always_comb begin
        eff_req = sgi_grp_e'(req_grp);
        if (tgt_grp == GRP_G0 && eff_req == GRP_G1S)
            eff_req = GRP_G0;
    end

    // Graded permission check for non-secure originators.
    always_comb begin
        perm_ok = 1'b1;
        if (req_ns && !sec_off) begin
            if (tgt_grp == GRP_G0 && int'(tgt_acl) < MIN_AC_G0)
                perm_ok = 1'b0;
            if (tgt_grp == GRP_G1S && int'(tgt_acl) < MIN_AC_G1S)
                perm_ok = 1'b0;
        end
    end

    // Final verdict, in priority order of the reasons.
    always_comb begin
        accept = 1'b0;
        why    = WHY_NONE;
        if (!id_ok)
            why = WHY_BADID;
        else if (eff_req == GRP_RSV)
            why = WHY_GROUP;
        else if (eff_req == GRP_G0 && tgt_grp != GRP_G0)
            why = WHY_GROUP;
        else if (!perm_ok)
            why = WHY_PERM;
        else
            accept = 1'b1;
    end
endmodule

// File: rtl/sgi_gate.sv
// Module: sgi_gate (top)
// Filters software-generated interrupt requests against the configured
// group and the non-secure permission fields, and registers the verdict.
// Assumes: the configuration inputs are valid in the cycle of the request.
// Outputs appear one clock after the request.
module sgi_gate
    import sgi_gate_pkg::*;
#(
    parameter int N_INT = 16,
    parameter int ID_W  = 5,
    parameter int AC_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ID_W-1:0]       req_id,
    input  logic [1:0]            req_grp,
    input  logic                  req_ns,
    input  logic                  sec_off,
    input  logic [N_INT-1:0]      grp_bits,
    input  logic [N_INT-1:0]      mod_bits,
    input  logic [N_INT*AC_W-1:0] nsac_word,
    output logic                  pend_set,
    output logic [3:0]            pend_id,
    output logic                  drop,
    output logic [1:0]            drop_why
);
    logic [N_INT-1:0][1:0]      cfg_grp;
    logic [N_INT-1:0][AC_W-1:0] acl;
    logic                       accept;
    logic [1:0]                 why;

    sgi_grp_map #(.N_INT(N_INT)) u_map (
        .grp_bits (grp_bits),
        .mod_bits (mod_bits),
        .sec_off  (sec_off),
        .cfg_grp  (cfg_grp)
    );

    sgi_acl_unpack #(.N_INT(N_INT), .AC_W(AC_W)) u_acl (
        .nsac_word (nsac_word),
        .acl       (acl)
    );

    sgi_verdict #(.N_INT(N_INT), .ID_W(ID_W), .AC_W(AC_W)) u_dec (
        .req_id  (req_id),
        .req_grp (req_grp),
        .req_ns  (req_ns),
        .sec_off (sec_off),
        .cfg_grp (cfg_grp),
        .acl     (acl),
        .accept  (accept),
        .why     (why)
    );

    // Register the verdict of the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_set <= 1'b0;
            pend_id  <= '0;
            drop     <= 1'b0;
            drop_why <= WHY_NONE;
        end else begin
            pend_set <= req_valid && accept;
            drop     <= req_valid && !accept;
            pend_id  <= req_id[3:0];
            drop_why <= req_valid ? why : WHY_NONE;
        end
    end

    // R1: outputs stay quiet in the cycle after reset.
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!pend_set && !drop));

    // R2: the two strobes never fire together.
    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_set && drop));

    // R2: any strobe is caused by a request one cycle earlier.
    p_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set || drop) |-> $past(req_valid));

    // R3: out-of-range IDs are dropped as invalid.
    p_badid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_valid && (int'(req_id) >= N_INT)) |->
            (drop && drop_why == WHY_BADID));

    // R8: a permission drop needs a non-secure originator with security enabled.
    p_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && drop_why == WHY_PERM) |-> $past(req_ns && !sec_off));

    // R11: the set-pending ID matches the request.
    p_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pend_set |-> (pend_id == $past(req_id[3:0]) && drop_why == WHY_NONE));

    // R12: the unused group code is always refused as a group mismatch.
    p_rsv_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_valid && (int'(req_id) < N_INT) && req_grp == 2'd3) |->
            (drop && drop_why == WHY_GROUP));
endmodule

// File: tb/sim_sgi_gate.sv
// Bench for sgi_gate: a vector table walked by one loop, then directed tests.
module sim_sgi_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_id = '0;
    logic [1:0]  req_grp = '0;
    logic        req_ns = 1'b0;
    logic        sec_off = 1'b0;
    logic [15:0] grp_bits = '0;
    logic [15:0] mod_bits = '0;
    logic [31:0] nsac_word = '0;
    logic        pend_set, drop;
    logic [3:0]  pend_id;
    logic [1:0]  drop_why;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sgi_gate u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .req_grp(req_grp), .req_ns(req_ns), .sec_off(sec_off),
        .grp_bits(grp_bits), .mod_bits(mod_bits), .nsac_word(nsac_word),
        .pend_set(pend_set), .pend_id(pend_id), .drop(drop), .drop_why(drop_why)
    );

    // Vector fields: rq[19:16] id[15:11] grp[10:9] ns[8] so[7] g[6] m[5] ac[4:3] exp_pend[2] exp_why[1:0]
    localparam int NV = 17;
    localparam logic [19:0] VEC [0:NV-1] = '{
        {4'd4,  5'd3,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0},  // R4 group0 accept
        {4'd6,  5'd4,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0},  // R6 fallback
        {4'd7,  5'd5,  2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd1},  // R7 target G1NS
        {4'd7,  5'd6,  2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 2'd1},  // R7 target G1S
        {4'd4,  5'd7,  2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 2'd0},  // R4 G1S accept
        {4'd9,  5'd8,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd2},  // R9 G0 ac0
        {4'd9,  5'd9,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 2'd0},  // R9 G0 ac1
        {4'd9,  5'd10, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 2'd2},  // R9 G1S ac1
        {4'd10, 5'd11, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 2'd0},  // R10 G1S ac2
        {4'd9,  5'd12, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 2'd0},  // R9 G1NS ac0
        {4'd5,  5'd13, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 2'd0},  // R5 mod ignored
        {4'd5,  5'd14, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 2'd1},  // R5 G1NS
        {4'd8,  5'd15, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd2},  // R8 fallback then perm
        {4'd3,  5'd16, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd3},  // R3 id 16
        {4'd3,  5'd31, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd3},  // R3 id 31
        {4'd12, 5'd0,  2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd1},  // R12 unused code
        {4'd8,  5'd1,  2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 2'd0}   // R8 no check when sec_off
    };

    // Record one comparison.
    task automatic chk(input string rq, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // Load configuration: target gets (g,m,ac), all others get the inverse.
    task automatic load_cfg(input int id, input logic g, input logic m, input logic [1:0] ac);
        for (int k = 0; k < 16; k++) begin
            grp_bits[k] = (k == id) ? g : ~g;
            mod_bits[k] = (k == id) ? m : ~m;
            nsac_word[2*k +: 2] = (k == id) ? ac : ~ac;
        end
    endtask

    // Issue one request at a falling edge and hold it over one rising edge.
    task automatic issue(input logic [4:0] id, input logic [1:0] grp, input logic ns);
        @(negedge clk);
        req_valid = 1'b1; req_id = id; req_grp = grp; req_ns = ns;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        string rq;
        // R1: a request held during reset leaves the outputs low
        req_valid = 1'b1; req_id = 5'd3;
        repeat (3) @(negedge clk);
        chk("R1", "pend in reset", int'(pend_set), 0);
        chk("R1", "drop in reset", int'(drop), 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pend after reset", int'(pend_set), 0);
        chk("R1", "drop after reset", int'(drop), 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            rq = $sformatf("R%0d", int'(v[19:16]));
            sec_off = v[7];
            load_cfg(int'(v[15:11]), v[6], v[5], v[4:3]);
            issue(v[15:11], v[10:9], v[8]);
            // Result registered at the edge just passed; sampled at this negedge.
            chk(rq, $sformatf("pend v%0d", i), int'(pend_set), int'(v[2]));
            chk(rq, $sformatf("drop v%0d", i), int'(drop), int'(!v[2]));
            chk(rq, $sformatf("why v%0d", i), int'(drop_why), int'(v[1:0]));
            if (v[2]) chk("R11", $sformatf("id v%0d", i), int'(pend_id), int'(v[14:11]));
            @(negedge clk);
            chk("R2", $sformatf("idle v%0d", i), int'(pend_set | drop), 0);
        end

        // R2: back-to-back requests each get their own verdict
        sec_off = 1'b0; load_cfg(2, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        req_valid = 1'b1; req_id = 5'd2; req_grp = 2'd0; req_ns = 1'b0;
        @(negedge clk);
        chk("R2", "b2b first pend", int'(pend_set), 1);
        chk("R11", "b2b first id", int'(pend_id), 2);
        req_id = 5'd20;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "b2b second drop", int'(drop), 1);
        chk("R3", "b2b second why", int'(drop_why), 3);

        // R10: field of interrupt 15 at the top of the word; only that field enables
        nsac_word = 32'h4000_0000; grp_bits = '0; mod_bits = '0;
        issue(5'd15, 2'd0, 1'b1);
        chk("R10", "top field pend", int'(pend_set), 1);
        nsac_word = 32'h3FFF_FFFF;
        issue(5'd15, 2'd0, 1'b1);
        chk("R10", "top field drop", int'(drop_why), 2);

        // R1: reset mid-run swallows a request
        @(negedge clk);
        req_valid = 1'b1; req_id = 5'd2; rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "midrun reset pend", int'(pend_set), 0);
        req_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "midrun after pend", int'(pend_set | drop), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule